// File: doc/BRIEF.md
# Ancillary Packet Checksum Checker and Inserter

This block sits in a 10-bit parallel video path and watches for ancillary data packets. Each packet opens with a start marker on its first flag word. The block counts the three flag words and then the three header words: the data identifier, the secondary identifier and the data count. It takes the number of user words from bits 7:0 of the data count word. Over the header and the user words it builds a running 9-bit checksum.

The checksum word is handled in one of two ways, chosen by `attachIn`. With `attachIn` high, every packet carries its own checksum word. The block compares that word with the computed one. On a mismatch it either puts the computed word in place of the received one (`forceIn` high) or passes the received word through and raises a sticky error bit (`forceIn` low). With `attachIn` low, the packet arrives without a checksum and the block appends the computed word itself. For that, the sender leaves one idle input cycle after the last user word.

All words, whether inside a packet or not, reach the output registered one cycle later. The last word of each packet is marked with `outEnd`.

Top module: `anc_csum_unit`

## Requirements
- R1: A word presented with `inValid` high appears on `outData` with `outValid` high exactly one clock later; with matching or absent checksums, the output word equals the input word.
- R2: After a word with `inStart` and `inValid` high, the block counts that word and two more valid words as flag words. The next three valid words are the header, and the third of them carries the user word count in bits 7:0.
- R3: The computed checksum is the sum, modulo 512, of bits 8:0 of every header word and user word. The checksum word carries that sum in bits 8:0 and the inverse of bit 8 in bit 9.
- R4: With `attachIn` low, the computed checksum word is output one cycle after the last user word is output, with `outValid` and `outEnd` high. The input must be idle in the cycle that follows the last user word.
- R5: A data count of zero ends the packet after the header. The checksum then covers the three header words only.
- R6: With `attachIn` high and a received checksum equal to the computed word, the output equals the input, `outEnd` marks the checksum word, and `csumErr` stays low.
- R7: With `attachIn` high, a mismatching received checksum and `forceIn` high, the computed word replaces the received one at the output and `csumErr` is not set.
- R8: With `attachIn` high, a mismatching received checksum and `forceIn` low, the received word passes unchanged and `csumErr` rises in the same cycle that this word appears at the output.
- R9: `csumErr` stays high until a one-cycle `errClear` pulse. It reads low in the cycle after that pulse.
- R10: A start marker in the middle of a packet abandons that packet and restarts the framing and the checksum from the new start word.
- R11: While `rst` is high and after it, before any input, `outValid`, `outEnd`, `outStart` and `csumErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 10 | Input video word |
| inValid | input | 1 | Input word qualifier |
| inStart | input | 1 | Marks the first flag word of a packet |
| attachIn | input | 1 | 1: checksum arrives with the packet; 0: block appends it |
| forceIn | input | 1 | 1: replace a mismatching received checksum |
| errClear | input | 1 | Write-one-to-clear pulse for `csumErr` |
| outData | output | 10 | Output video word |
| outValid | output | 1 | Output word qualifier |
| outStart | output | 1 | Start marker delayed with its word |
| outEnd | output | 1 | Marks the checksum word of a packet |
| csumErr | output | 1 | Sticky received-checksum mismatch flag |

## Verification
Every input word is due at the output one edge after it is driven, so the bench drives on falling edges and reads the output on the next falling edge. An appended checksum is due one edge after the last user word appears. An error set by a bad received checksum is due on the same edge as that checksum word. `csumErr` reads low one edge after an `errClear` pulse. A monitor logs each valid output word with its end marker and error bit on falling edges. Each scenario compares that log with a stream the bench computes from the requirements, so that both the position and the value of the checksum word are checked in the cycle they are due.

// File: rtl/anc_csum_pkg.sv
package anc_csum_pkg;

  // Framing phases of the packet walker
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLAG,
    ST_HEAD,
    ST_USER,
    ST_CHECK,
    ST_INSERT
  } ctrlState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic startWord;   // current input word opens a packet
    logic clearSum;    // reset the running checksum
    logic addSum;      // accumulate current input word
    logic checkWord;   // current input word is the received checksum
    logic insertWord;  // emit computed checksum this cycle
  } dpCtrl_t;

  localparam int FLAG_LEN = 3;  // flag words per packet
  localparam int HEAD_LEN = 3;  // identifier, secondary identifier, count

endpackage

// File: rtl/anc_csum_ctrl.sv
module anc_csum_ctrl
  import anc_csum_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             inStart,
  input  logic [CNT_W-1:0] countIn,
  input  logic             attachIn,
  output dpCtrl_t          strb
);

  localparam logic [CNT_W-1:0] FLAG_LAST = CNT_W'(FLAG_LEN - 1);
  localparam logic [CNT_W-1:0] HEAD_LAST = CNT_W'(HEAD_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO  = '0;

  ctrlState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  ctrlState_t tailState;
  logic startHit;

  assign startHit  = inValid && inStart;
  assign tailState = attachIn ? ST_CHECK : ST_INSERT;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    if (startHit) begin
      stateD = ST_FLAG;
      cntD   = CNT_ONE;
    end else begin
      case (stateQ)
        ST_FLAG: begin
          if (inValid) begin
            if (cntQ == FLAG_LAST) begin
              stateD = ST_HEAD;
              cntD   = CNT_ZERO;
            end else begin
              cntD = cntQ + CNT_ONE;
            end
          end
        end
        ST_HEAD: begin
          if (inValid) begin
            if (cntQ == HEAD_LAST) begin
              cntD   = countIn;
              stateD = (countIn == CNT_ZERO) ? tailState : ST_USER;
            end else begin
              cntD = cntQ + CNT_ONE;
            end
          end
        end
        ST_USER: begin
          if (inValid) begin
            cntD = cntQ - CNT_ONE;
            if (cntQ == CNT_ONE) begin
              stateD = tailState;
            end
          end
        end
        ST_CHECK: begin
          if (inValid) begin
            stateD = ST_IDLE;
          end
        end
        ST_INSERT: begin
          stateD = ST_IDLE;
        end
        default: begin
          stateD = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      cntQ   <= CNT_ZERO;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    strb.startWord  = startHit;
    strb.clearSum   = startHit;
    strb.addSum     = inValid && !inStart &&
                      ((stateQ == ST_HEAD) || (stateQ == ST_USER));
    strb.checkWord  = inValid && !inStart && (stateQ == ST_CHECK);
    strb.insertWord = (stateQ == ST_INSERT);
  end

endmodule

// File: rtl/anc_csum_dp.sv
module anc_csum_dp
  import anc_csum_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              forceIn,
  input  logic              errClear,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outStart,
  output logic              outEnd,
  output logic              csumErr
);

  localparam int SUM_W = DATA_W - 1;

  logic [SUM_W-1:0]  sumQ;
  logic [DATA_W-1:0] calcWord;
  logic              mismatch;
  logic              replaceWord;
  logic              reportErr;

  // Running checksum over header and user words
  always_ff @(posedge clk) begin
    if (rst || strb.clearSum) begin
      sumQ <= '0;
    end else if (strb.addSum) begin
      sumQ <= sumQ + inData[SUM_W-1:0];
    end
  end

  assign calcWord    = {~sumQ[SUM_W-1], sumQ};
  assign mismatch    = strb.checkWord && (inData != calcWord);
  assign replaceWord = mismatch && forceIn;
  assign reportErr   = mismatch && !forceIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
      outStart <= 1'b0;
      outEnd   <= 1'b0;
    end else begin
      outValid <= inValid || strb.insertWord;
      outStart <= strb.startWord && !strb.insertWord;
      outEnd   <= strb.insertWord || strb.checkWord;
      if (strb.insertWord || replaceWord) begin
        outData <= calcWord;
      end else if (inValid) begin
        outData <= inData;
      end
    end
  end

  // Sticky error; a new mismatch wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      csumErr <= 1'b0;
    end else if (reportErr) begin
      csumErr <= 1'b1;
    end else if (errClear) begin
      csumErr <= 1'b0;
    end
  end

endmodule

// File: rtl/anc_csum_unit.sv
module anc_csum_unit
  import anc_csum_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              attachIn,
  input  logic              forceIn,
  input  logic              errClear,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outStart,
  output logic              outEnd,
  output logic              csumErr
);

  dpCtrl_t strb;

  anc_csum_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inStart (inStart),
    .countIn (inData[CNT_W-1:0]),
    .attachIn(attachIn),
    .strb    (strb)
  );

  anc_csum_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .inData  (inData),
    .inValid (inValid),
    .forceIn (forceIn),
    .errClear(errClear),
    .outData (outData),
    .outValid(outValid),
    .outStart(outStart),
    .outEnd  (outEnd),
    .csumErr (csumErr)
  );

endmodule

// File: rtl/anc_csum_checker.sv
module anc_csum_checker #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              attachIn,
  input logic              forceIn,
  input logic              errClear,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outEnd,
  input logic              csumErr
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R1

  AST_END_HAS_VALID: assert property (@(posedge clk) disable iff (rst)
    outEnd |-> outValid); // R4

  AST_CSUM_FORM: assert property (@(posedge clk) disable iff (rst)
    (outEnd && $past(forceIn || !attachIn)) |-> (outData[DATA_W-1] != outData[DATA_W-2])); // R3

  AST_ERR_ONLY_UNFORCED: assert property (@(posedge clk) disable iff (rst)
    $rose(csumErr) |-> ($past(attachIn) && !$past(forceIn) && outEnd)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (csumErr && !errClear) |=> csumErr); // R9

  AST_NO_ERR_WHEN_FORCED: assert property (@(posedge clk) disable iff (rst)
    (!csumErr && forceIn) |=> !csumErr); // R7

endmodule

bind anc_csum_unit anc_csum_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .attachIn(attachIn),
  .forceIn (forceIn),
  .errClear(errClear),
  .outData (outData),
  .outValid(outValid),
  .outEnd  (outEnd),
  .csumErr (csumErr)
);

// File: tb/anc_csum_unit_test.sv
module anc_csum_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inStart = 1'b0;
  logic       attachIn = 1'b0;
  logic       forceIn = 1'b0;
  logic       errClear = 1'b0;
  logic [9:0] outData;
  logic       outValid, outStart, outEnd, csumErr;

  always #10 clk = ~clk;  // 50 MHz

  anc_csum_unit uut (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid),
    .inStart(inStart), .attachIn(attachIn), .forceIn(forceIn),
    .errClear(errClear), .outData(outData), .outValid(outValid),
    .outStart(outStart), .outEnd(outEnd), .csumErr(csumErr)
  );

  int checks = 0;
  int fails  = 0;
  logic [9:0] capData[$];
  logic       capEnd[$];
  logic       capErr[$];
  logic [9:0] expData[$];

  always @(negedge clk) begin
    if (!rst && outValid) begin
      capData.push_back(outData);
      capEnd.push_back(outEnd);
      capErr.push_back(csumErr);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [9:0] d, input logic s);
    inData  = d;
    inStart = s;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    inStart = 1'b0;
  endtask

  task automatic clearLog();
    capData.delete();
    capEnd.delete();
    capErr.delete();
    expData.delete();
  endtask

  // mode 0: no checksum sent; 1: correct checksum sent; 2: corrupted checksum sent
  task automatic sendPacket(input logic [9:0] did, input logic [9:0] sdid,
                            input int n, input int seed, input int mode);
    logic [9:0] words[$];
    logic [8:0] sum;
    logic [9:0] cw;
    logic [9:0] bad;
    words.push_back(10'h000);
    words.push_back(10'h3FF);
    words.push_back(10'h3FF);
    words.push_back(did);
    words.push_back(sdid);
    words.push_back({2'b01, 8'(n)});
    for (int i = 0; i < n; i++) words.push_back(10'((seed + i * 37) & 10'h3FF));
    sum = '0;
    for (int i = 3; i < words.size(); i++) sum = sum + words[i][8:0];
    cw  = {~sum[8], sum};
    bad = cw ^ 10'h001;
    for (int i = 0; i < words.size(); i++) begin
      drive(words[i], i == 0);
      expData.push_back(words[i]);
    end
    if (mode == 0) begin
      expData.push_back(cw);
    end else if (mode == 1) begin
      drive(cw, 1'b0);
      expData.push_back(cw);
    end else begin
      drive(bad, 1'b0);
      expData.push_back(forceIn ? cw : bad);
    end
    idle(3);
  endtask

  task automatic compareStream(input string req);
    int bad = -1;
    int ends = 0;
    check(capData.size() == expData.size(), req, "word count",
          capData.size(), expData.size());
    if (capData.size() == expData.size()) begin
      for (int i = 0; i < expData.size(); i++)
        if (bad < 0 && capData[i] != expData[i]) bad = i;
      check(bad < 0, req, "stream word",
            bad < 0 ? 0 : int'(capData[bad]), bad < 0 ? 0 : int'(expData[bad]));
      foreach (capEnd[i]) if (capEnd[i]) ends++;
      check(ends == 1 && capEnd[capEnd.size()-1], req, "end marker count",
            ends, 1);
    end
  endtask

  task automatic testReset();
    check(outValid == 0 && outEnd == 0 && outStart == 0 && csumErr == 0,
          "R11", "reset outputs", {outValid, outEnd, outStart, csumErr}, 0);
  endtask

  task automatic testLatency();
    drive(10'h155, 1'b0);
    check(outValid == 1 && outData == 10'h155, "R1", "one-cycle passthrough",
          outData, 10'h155);
    idle(1);
    check(outValid == 0, "R1", "valid drops after idle", outValid, 0);
  endtask

  task automatic testGenerate();
    attachIn = 1'b0;
    clearLog();
    sendPacket(10'h241, 10'h105, 4, 10'h123, 0);
    compareStream("R4");
    clearLog();
    sendPacket(10'h3F0, 10'h1FF, 20, 10'h2F7, 0);
    compareStream("R3");
    check(capData.size() > 0 && capData[capData.size()-1][9] != capData[capData.size()-1][8],
          "R3", "bit 9 inverse of bit 8", capData.size() > 0 ? int'(capData[capData.size()-1]) : 0, 0);
  endtask

  task automatic testZeroCount();
    attachIn = 1'b0;
    clearLog();
    sendPacket(10'h160, 10'h160, 0, 0, 0);
    compareStream("R5");
  endtask

  task automatic testFraming();
    attachIn = 1'b0;
    clearLog();
    sendPacket(10'h0AA, 10'h155, 1, 10'h3C3, 0);
    compareStream("R2");
  endtask

  task automatic testAttachGood();
    attachIn = 1'b1;
    forceIn  = 1'b0;
    clearLog();
    sendPacket(10'h251, 10'h101, 6, 10'h0F0, 1);
    compareStream("R6");
    check(csumErr == 0, "R6", "no error on match", csumErr, 0);
  endtask

  task automatic testForce();
    attachIn = 1'b1;
    forceIn  = 1'b1;
    clearLog();
    sendPacket(10'h222, 10'h133, 5, 10'h1AB, 2);
    compareStream("R7");
    check(csumErr == 0, "R7", "no error when forced", csumErr, 0);
    forceIn = 1'b0;
  endtask

  task automatic testReport();
    attachIn = 1'b1;
    forceIn  = 1'b0;
    clearLog();
    sendPacket(10'h2C0, 10'h111, 3, 10'h077, 2);
    compareStream("R8");
    if (capErr.size() >= 2) begin
      check(capErr[capErr.size()-1] == 1 && capErr[capErr.size()-2] == 0,
            "R8", "error rises with checksum word",
            {capErr[capErr.size()-2], capErr[capErr.size()-1]}, 1);
    end
  endtask

  task automatic testSticky();
    idle(4);
    check(csumErr == 1, "R9", "error held", csumErr, 1);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    check(csumErr == 0, "R9", "error cleared", csumErr, 0);
  endtask

  task automatic testRestart();
    attachIn = 1'b0;
    clearLog();
    drive(10'h000, 1'b1);
    drive(10'h3FF, 1'b0);
    drive(10'h3FF, 1'b0);
    drive(10'h101, 1'b0);
    expData.push_back(10'h000);
    expData.push_back(10'h3FF);
    expData.push_back(10'h3FF);
    expData.push_back(10'h101);
    sendPacket(10'h244, 10'h102, 3, 10'h300, 0);
    compareStream("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(2);
    testReset();
    rst = 1'b0;
    idle(1);
    testReset();
    testLatency();
    idle(2);
    testFraming();
    testGenerate();
    testZeroCount();
    testAttachGood();
    testForce();
    testReport();
    testSticky();
    testRestart();
    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule